// File: doc/BRIEF.md
# SCSI Bus Control Register Unit

This block sits between an 8-bit host processor port and the control and data lines of a SCSI bus. The host selects one of eight byte-wide locations with a 3-bit address, a chip select and single-cycle read or write strobes. Most locations mean different things for reads and writes. Through them the host sets which control lines the device drives, places a byte and its parity on the data lines, chooses initiator or target role, and reads back the live state of the bus.

Each bus line is modelled as a registered drive enable. The wired-OR bus and the electrical drivers are outside the block, and the bus state comes back in on the input lines. The block also runs a simple arbitration sequence for its own ID. It latches incoming bytes on the handshake edge and checks their parity. It raises one interrupt line for selection, parity, lost-busy and phase-mismatch events. Reading a dedicated location clears that line.

Top module: `scsi_busctl`

## Requirements
- R1: After reset every host register, flag and drive enable is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write to address 0 loads the outgoing data byte. A read of address 0 returns the data lines as seen on the bus. `rdata_o` changes only in the cycle after a read strobe.
- R3: Writing address 1 sets the line-assert bits: bit 7 RST, bit 4 ACK, bit 3 BSY, bit 2 SEL, bit 1 ATN, bit 0 assert-data. A write with bit 6 set disables every drive enable, and write bit 5 drives `diff_en_o`. Reading address 1 returns bits 7 and 4:0 as written, bit 6 = arbitration in progress and bit 5 = arbitration lost.
- R4: Drive enables follow the registers one cycle after the write. RST, BSY and SEL are driven in either role. ATN and ACK are driven only when mode bit 6 (target) is 0. REQ, MSG, C/D and I/O follow address 3 bits 3, 2, 1 and 0 only when mode bit 6 is 1.
- R5: `data_oe_o` is 1 while the device arbitrates. It is also 1 when assert-data is set and address 3 bit 0 (I/O) is 0. `dbp_o` gives odd parity over `data_o`.
- R6: Reading address 4 returns the live lines as {RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP}, from bit 7 down to bit 0.
- R7: Reading address 5 returns bit 5 parity error, bit 4 the IRQ state, bit 3 phase match, bit 2 busy error, bit 1 ATN and bit 0 ACK. Bits 7:6 read 0. Phase match is 1 while the live {MSG,C/D,I/O} equals address 3 bits 2:0.
- R8: Writing address 4 loads a selection mask. IRQ is raised when BSY is low, SEL is high and a data line set in the mask is high, all three at once. No IRQ is raised if the mask misses the active lines or if BSY is high.
- R9: A read of address 7 clears IRQ, the parity error flag and the busy error flag.
- R10: On a falling REQ (mode bit 6 = 0) or a falling ACK (mode bit 6 = 1), the data lines are latched and become readable at address 6. If mode bit 5 is set and data plus DBP has an even count of ones, the parity error flag is set. IRQ is raised as well when mode bit 4 is set.
- R11: With mode bit 2 set, a high-to-low change of BSY sets the busy error flag and raises IRQ. With mode bit 2 clear, nothing happens.
- R12: With mode bit 1 set, a loss of phase match raises IRQ.
- R13: Setting mode bit 0 starts arbitration. After FREE_CYC consecutive cycles with BSY and SEL low, the device drives BSY and its own ID bit and reports arbitration in progress. If a higher ID bit appears within the next ARB_CYC cycles, the device reports lost and stops driving. Clearing mode bit 0 ends arbitration.
- R14: The mode register at address 2 reads back all 8 bits. Address 3 reads back bits 3:0, with bits 7:4 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt request |
| bus_rst_i | input | 1 | Live RST line |
| bus_bsy_i | input | 1 | Live BSY line |
| bus_sel_i | input | 1 | Live SEL line |
| bus_atn_i | input | 1 | Live ATN line |
| bus_ack_i | input | 1 | Live ACK line |
| bus_req_i | input | 1 | Live REQ line |
| bus_msg_i | input | 1 | Live MSG line |
| bus_cd_i | input | 1 | Live C/D line |
| bus_io_i | input | 1 | Live I/O line |
| bus_data_i | input | 8 | Live data lines |
| bus_dbp_i | input | 1 | Live data parity line |
| drv_rst_o | output | 1 | Drive RST |
| drv_bsy_o | output | 1 | Drive BSY |
| drv_sel_o | output | 1 | Drive SEL |
| drv_atn_o | output | 1 | Drive ATN |
| drv_ack_o | output | 1 | Drive ACK |
| drv_req_o | output | 1 | Drive REQ |
| drv_msg_o | output | 1 | Drive MSG |
| drv_cd_o | output | 1 | Drive C/D |
| drv_io_o | output | 1 | Drive I/O |
| data_o | output | 8 | Outgoing data byte |
| dbp_o | output | 1 | Outgoing odd parity |
| data_oe_o | output | 1 | Data and parity drive enable |
| diff_en_o | output | 1 | Differential driver enable |

## Verification
The assertions assume that a chip-select access carries only one strobe and that each strobe lasts a single cycle. Without this, the clear-on-read property and the check that read data only changes after a read would not describe a real access. They also assume that reset is applied from time zero. The bench drives every strobe for exactly one cycle and never raises read and write together. It holds each bus-line change for several cycles, so every edge the event logic sees is a deliberate one. It models the bus as the OR of its own lines and the design's drive enables.

// File: rtl/scsi_busctl_pkg.sv
package scsi_busctl_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  // host addresses
  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_ICR  = 3'd1;
  localparam logic [AW-1:0] A_MODE = 3'd2;
  localparam logic [AW-1:0] A_TCR  = 3'd3;
  localparam logic [AW-1:0] A_STAT = 3'd4;
  localparam logic [AW-1:0] A_BSR  = 3'd5;
  localparam logic [AW-1:0] A_IDAT = 3'd6;
  localparam logic [AW-1:0] A_CLR  = 3'd7;

  // line-assert register bits
  localparam int IC_RST  = 7;
  localparam int IC_TRI  = 6;
  localparam int IC_DIFF = 5;
  localparam int IC_ACK  = 4;
  localparam int IC_BSY  = 3;
  localparam int IC_SEL  = 2;
  localparam int IC_ATN  = 1;
  localparam int IC_DAT  = 0;

  // mode register bits
  localparam int MD_TGT  = 6;
  localparam int MD_PCHK = 5;
  localparam int MD_PINT = 4;
  localparam int MD_MBSY = 2;
  localparam int MD_DMA  = 1;
  localparam int MD_ARB  = 0;

  typedef struct packed {
    logic rst;
    logic bsy;
    logic req;
    logic msg;
    logic cd;
    logic io;
    logic sel;
    logic atn;
    logic ack;
  } ctl_t;

  typedef enum logic [2:0] {
    ARB_IDLE,
    ARB_FREE,
    ARB_RUN,
    ARB_WON,
    ARB_LOST
  } arb_st_t;
endpackage

// File: rtl/scsi_busctl_host.sv
module scsi_busctl_host
  import scsi_busctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  ctl_t          ctl,
  input  logic [DW-1:0] data_q,
  input  logic          dbp_q,
  input  logic          aip,
  input  logic          lost,
  input  logic          irq,
  input  logic          perr,
  input  logic          berr,
  input  logic          pmatch,
  input  logic [DW-1:0] idat,
  output logic [DW-1:0] odr,
  output logic [DW-1:0] icr,
  output logic [3:0]    tcr,
  output logic [DW-1:0] sel_en,
  output logic          m_tgt,
  output logic          m_pchk,
  output logic          m_pint,
  output logic          m_mbsy,
  output logic          m_dma,
  output logic          m_arb,
  output logic          clr
);
  logic [DW-1:0] mode_q;
  logic [DW-1:0] rmux;

  assign m_tgt  = mode_q[MD_TGT];
  assign m_pchk = mode_q[MD_PCHK];
  assign m_pint = mode_q[MD_PINT];
  assign m_mbsy = mode_q[MD_MBSY];
  assign m_dma  = mode_q[MD_DMA];
  assign m_arb  = mode_q[MD_ARB];
  assign clr    = cs && rd && (addr == A_CLR);

  always_comb begin
    unique case (addr)
      A_DATA:  rmux = data_q;
      A_ICR:   rmux = {icr[IC_RST], aip, lost, icr[IC_ACK:IC_DAT]};
      A_MODE:  rmux = mode_q;
      A_TCR:   rmux = {4'b0, tcr};
      A_STAT:  rmux = {ctl.rst, ctl.bsy, ctl.req, ctl.msg, ctl.cd, ctl.io, ctl.sel, dbp_q};
      A_BSR:   rmux = {2'b00, perr, irq, pmatch, berr, ctl.atn, ctl.ack};
      A_IDAT:  rmux = idat;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      odr    <= '0;
      icr    <= '0;
      mode_q <= '0;
      tcr    <= '0;
      sel_en <= '0;
      rdata  <= '0;
    end else begin
      if (cs && wr) begin
        unique case (addr)
          A_DATA:  odr    <= wdata;
          A_ICR:   icr    <= wdata;
          A_MODE:  mode_q <= wdata;
          A_TCR:   tcr    <= wdata[3:0];
          A_STAT:  sel_en <= wdata;
          default: ;
        endcase
      end
      if (cs && rd) rdata <= rmux;
    end
  end
endmodule

// File: rtl/scsi_busctl_evt.sv
module scsi_busctl_evt
  import scsi_busctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl_i,
  input  logic [DW-1:0] data_i,
  input  logic          dbp_i,
  input  logic          m_tgt,
  input  logic          m_pchk,
  input  logic          m_pint,
  input  logic          m_mbsy,
  input  logic          m_dma,
  input  logic [2:0]    phase_want,
  input  logic [DW-1:0] sel_en,
  input  logic          clr,
  output ctl_t          ctl_q,
  output logic [DW-1:0] data_q,
  output logic          dbp_q,
  output logic [DW-1:0] idat,
  output logic          pmatch,
  output logic          perr,
  output logic          berr,
  output logic          irq,
  output logic          irq_set
);
  ctl_t          ctl_p;
  logic [DW-1:0] data_p;
  logic          dbp_p;
  logic          selc_q, pm_q;
  logic          stb_now, stb_prev, latch;
  logic          par_ev, sel_cond, sel_ev, bsy_ev, ph_ev;

  assign stb_now  = m_tgt ? ctl_q.ack : ctl_q.req;
  assign stb_prev = m_tgt ? ctl_p.ack : ctl_p.req;
  assign latch    = stb_prev && !stb_now;
  // odd parity expected: an even count of ones is an error
  assign par_ev   = latch && m_pchk && !(^{data_p, dbp_p});
  assign sel_cond = !ctl_q.bsy && ctl_q.sel && (|(data_q & sel_en));
  assign sel_ev   = sel_cond && !selc_q;
  assign bsy_ev   = m_mbsy && ctl_p.bsy && !ctl_q.bsy;
  assign pmatch   = ({ctl_q.msg, ctl_q.cd, ctl_q.io} == phase_want);
  assign ph_ev    = m_dma && pm_q && !pmatch;
  assign irq_set  = sel_ev || (par_ev && m_pint) || bsy_ev || ph_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      data_q <= '0;
      dbp_q  <= 1'b0;
      ctl_p  <= '0;
      data_p <= '0;
      dbp_p  <= 1'b0;
      selc_q <= 1'b0;
      pm_q   <= 1'b0;
      idat   <= '0;
      perr   <= 1'b0;
      berr   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      ctl_q  <= ctl_i;
      data_q <= data_i;
      dbp_q  <= dbp_i;
      ctl_p  <= ctl_q;
      data_p <= data_q;
      dbp_p  <= dbp_q;
      selc_q <= sel_cond;
      pm_q   <= pmatch;
      if (latch) idat <= data_p;
      if (par_ev) perr <= 1'b1;
      else if (clr) perr <= 1'b0;
      if (bsy_ev) berr <= 1'b1;
      else if (clr) berr <= 1'b0;
      if (irq_set) irq <= 1'b1;
      else if (clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_busctl_arb.sv
module scsi_busctl_arb
  import scsi_busctl_pkg::*;
#(
  parameter int OWN_ID   = 6,
  parameter int FREE_CYC = 8,
  parameter int ARB_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bus_bsy,
  input  logic          bus_sel,
  input  logic [DW-1:0] bus_data,
  output logic          aip,
  output logic          lost,
  output logic          drive
);
  localparam int            CMAX     = (FREE_CYC > ARB_CYC) ? FREE_CYC : ARB_CYC;
  localparam int            CNT_W    = $clog2(CMAX + 1);
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << (OWN_ID + 1)) - 1);
  localparam logic [DW-1:0] HI_MASK  = ~LOW_MASK;

  arb_st_t           st_q;
  logic [CNT_W-1:0]  cnt_q;

  assign aip   = (st_q == ARB_RUN) || (st_q == ARB_WON);
  assign lost  = (st_q == ARB_LOST);
  assign drive = aip;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ARB_IDLE;
      cnt_q <= '0;
    end else if (!start) begin
      st_q  <= ARB_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ARB_IDLE: begin
          st_q  <= ARB_FREE;
          cnt_q <= '0;
        end
        ARB_FREE: begin
          if (bus_bsy || bus_sel) cnt_q <= '0;
          else if (cnt_q == CNT_W'(FREE_CYC - 1)) begin
            st_q  <= ARB_RUN;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ARB_RUN: begin
          if (|(bus_data & HI_MASK)) st_q <= ARB_LOST;
          else if (cnt_q == CNT_W'(ARB_CYC - 1)) st_q <= ARB_WON;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_busctl.sv
module scsi_busctl
  import scsi_busctl_pkg::*;
#(
  parameter int OWN_ID   = 6,
  parameter int FREE_CYC = 8,
  parameter int ARB_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  input  logic       bus_rst_i,
  input  logic       bus_bsy_i,
  input  logic       bus_sel_i,
  input  logic       bus_atn_i,
  input  logic       bus_ack_i,
  input  logic       bus_req_i,
  input  logic       bus_msg_i,
  input  logic       bus_cd_i,
  input  logic       bus_io_i,
  input  logic [7:0] bus_data_i,
  input  logic       bus_dbp_i,
  output logic       drv_rst_o,
  output logic       drv_bsy_o,
  output logic       drv_sel_o,
  output logic       drv_atn_o,
  output logic       drv_ack_o,
  output logic       drv_req_o,
  output logic       drv_msg_o,
  output logic       drv_cd_o,
  output logic       drv_io_o,
  output logic [7:0] data_o,
  output logic       dbp_o,
  output logic       data_oe_o,
  output logic       diff_en_o
);
  localparam logic [DW-1:0] ID_BIT = DW'(1) << OWN_ID;

  ctl_t          ctl_in, ctl_q;
  logic [DW-1:0] data_q, idat, odr_q, icr_q, sel_en;
  logic [3:0]    tcr_q;
  logic          dbp_q, pmatch, perr, berr, irq_set, clr;
  logic          m_tgt, m_pchk, m_pint, m_mbsy, m_dma, m_arb;
  logic          arb_aip, arb_lost, arb_drive;
  logic          en;
  logic [DW-1:0] d_val;

  assign ctl_in = '{rst: bus_rst_i, bsy: bus_bsy_i, req: bus_req_i, msg: bus_msg_i,
                    cd: bus_cd_i, io: bus_io_i, sel: bus_sel_i, atn: bus_atn_i,
                    ack: bus_ack_i};

  scsi_busctl_host u_host (
    .clk(clk), .rst(rst), .cs(cs_i), .rd(rd_i), .wr(wr_i), .addr(addr_i),
    .wdata(wdata_i), .rdata(rdata_o), .ctl(ctl_q), .data_q(data_q), .dbp_q(dbp_q),
    .aip(arb_aip), .lost(arb_lost), .irq(irq_o), .perr(perr), .berr(berr),
    .pmatch(pmatch), .idat(idat), .odr(odr_q), .icr(icr_q), .tcr(tcr_q),
    .sel_en(sel_en), .m_tgt(m_tgt), .m_pchk(m_pchk), .m_pint(m_pint),
    .m_mbsy(m_mbsy), .m_dma(m_dma), .m_arb(m_arb), .clr(clr)
  );

  scsi_busctl_evt u_evt (
    .clk(clk), .rst(rst), .ctl_i(ctl_in), .data_i(bus_data_i), .dbp_i(bus_dbp_i),
    .m_tgt(m_tgt), .m_pchk(m_pchk), .m_pint(m_pint), .m_mbsy(m_mbsy),
    .m_dma(m_dma), .phase_want(tcr_q[2:0]), .sel_en(sel_en), .clr(clr),
    .ctl_q(ctl_q), .data_q(data_q), .dbp_q(dbp_q), .idat(idat), .pmatch(pmatch),
    .perr(perr), .berr(berr), .irq(irq_o), .irq_set(irq_set)
  );

  scsi_busctl_arb #(.OWN_ID(OWN_ID), .FREE_CYC(FREE_CYC), .ARB_CYC(ARB_CYC)) u_arb (
    .clk(clk), .rst(rst), .start(m_arb), .bus_bsy(ctl_q.bsy), .bus_sel(ctl_q.sel),
    .bus_data(data_q), .aip(arb_aip), .lost(arb_lost), .drive(arb_drive)
  );

  assign en    = !icr_q[IC_TRI];
  assign d_val = arb_drive ? ID_BIT : odr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_rst_o <= 1'b0;
      drv_bsy_o <= 1'b0;
      drv_sel_o <= 1'b0;
      drv_atn_o <= 1'b0;
      drv_ack_o <= 1'b0;
      drv_req_o <= 1'b0;
      drv_msg_o <= 1'b0;
      drv_cd_o  <= 1'b0;
      drv_io_o  <= 1'b0;
      data_o    <= '0;
      dbp_o     <= 1'b0;
      data_oe_o <= 1'b0;
      diff_en_o <= 1'b0;
    end else begin
      drv_rst_o <= en && icr_q[IC_RST];
      drv_bsy_o <= en && (icr_q[IC_BSY] || arb_drive);
      drv_sel_o <= en && icr_q[IC_SEL];
      drv_atn_o <= en && !m_tgt && icr_q[IC_ATN];
      drv_ack_o <= en && !m_tgt && icr_q[IC_ACK];
      drv_req_o <= en && m_tgt && tcr_q[3];
      drv_msg_o <= en && m_tgt && tcr_q[2];
      drv_cd_o  <= en && m_tgt && tcr_q[1];
      drv_io_o  <= en && m_tgt && tcr_q[0];
      data_o    <= d_val;
      dbp_o     <= ~^d_val;
      data_oe_o <= en && (arb_drive || (icr_q[IC_DAT] && !tcr_q[0]));
      diff_en_o <= icr_q[IC_DIFF];
    end
  end
endmodule

// File: rtl/scsi_busctl_chk.sv
module scsi_busctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_i,
  input logic       rd_i,
  input logic [2:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       data_oe_o,
  input logic       drv_bsy_o,
  input logic       drv_sel_o,
  input logic       tri_q,
  input logic       irq_set,
  input logic       aip,
  input logic       lost
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && !data_oe_o && !drv_bsy_o && rdata_o == 8'h00));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(cs_i && rd_i) |=> $stable(rdata_o));

  p_tristate_r3: assert property (@(posedge clk) disable iff (rst)
    tri_q |=> (!data_oe_o && !drv_bsy_o && !drv_sel_o));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(irq_set));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_i && rd_i && addr_i == 3'd7 && !irq_set) |=> !irq_o);

  p_lost_from_run_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> $past(aip));
endmodule

bind scsi_busctl scsi_busctl_chk u_chk (
  .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .data_oe_o(data_oe_o),
  .drv_bsy_o(drv_bsy_o), .drv_sel_o(drv_sel_o), .tri_q(icr_q[6]),
  .irq_set(irq_set), .aip(arb_aip), .lost(arb_lost)
);

// File: tb/sim_scsi_busctl.sv
`timescale 1ns/1ps
module sim_scsi_busctl;
  localparam int OWN = 6;
  localparam int FREE_N = 8;
  localparam int ARB_N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  logic o_rst = 0, o_bsy = 0, o_sel = 0, o_atn = 0, o_ack = 0, o_req = 0;
  logic o_msg = 0, o_cd = 0, o_io = 0, o_dbp = 0;
  logic [7:0] o_data = '0;
  logic b_rst, b_bsy, b_sel, b_atn, b_ack, b_req, b_msg, b_cd, b_io, b_dbp;
  logic [7:0] b_data;
  logic d_rst, d_bsy, d_sel, d_atn, d_ack, d_req, d_msg, d_cd, d_io, d_dbp, d_oe, d_diff;
  logic [7:0] d_data;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // wired-OR bus
  assign b_rst  = o_rst | d_rst;
  assign b_bsy  = o_bsy | d_bsy;
  assign b_sel  = o_sel | d_sel;
  assign b_atn  = o_atn | d_atn;
  assign b_ack  = o_ack | d_ack;
  assign b_req  = o_req | d_req;
  assign b_msg  = o_msg | d_msg;
  assign b_cd   = o_cd  | d_cd;
  assign b_io   = o_io  | d_io;
  assign b_data = o_data | (d_oe ? d_data : 8'h00);
  assign b_dbp  = o_dbp | (d_oe & d_dbp);

  scsi_busctl #(.OWN_ID(OWN), .FREE_CYC(FREE_N), .ARB_CYC(ARB_N)) u0 (
    .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .bus_rst_i(b_rst), .bus_bsy_i(b_bsy), .bus_sel_i(b_sel), .bus_atn_i(b_atn),
    .bus_ack_i(b_ack), .bus_req_i(b_req), .bus_msg_i(b_msg), .bus_cd_i(b_cd),
    .bus_io_i(b_io), .bus_data_i(b_data), .bus_dbp_i(b_dbp),
    .drv_rst_o(d_rst), .drv_bsy_o(d_bsy), .drv_sel_o(d_sel), .drv_atn_o(d_atn),
    .drv_ack_o(d_ack), .drv_req_o(d_req), .drv_msg_o(d_msg), .drv_cd_o(d_cd),
    .drv_io_o(d_io), .data_o(d_data), .dbp_o(d_dbp), .data_oe_o(d_oe),
    .diff_en_o(d_diff)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = v;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    @(negedge clk);
    cs = 0; rd = 0;
    v = rdata;
  endtask

  function automatic logic [7:0] exp_stat();
    return {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_dbp};
  endfunction

  function automatic logic [7:0] exp_bsr(input logic [2:0] want, input logic pe,
                                         input logic iq, input logic be);
    logic pm;
    pm = ({b_msg, b_cd, b_io} == want);
    return {2'b00, pe, iq, pm, be, b_atn, b_ack};
  endfunction

  function automatic logic [8:0] exp_drv(input logic [7:0] ic, input logic tgt,
                                         input logic [3:0] tc);
    logic en;
    en = !ic[6];
    return {en & ic[7], en & ic[3], en & ic[2], en & !tgt & ic[1], en & !tgt & ic[4],
            en & tgt & tc[3], en & tgt & tc[2], en & tgt & tc[1], en & tgt & tc[0]};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5C51));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 drives", {6'b0, d_rst, d_bsy, d_sel, d_atn, d_ack, d_req, d_msg, d_cd, d_io, d_oe}, 16'h0);
    chk("R1 rdata", {8'h0, rdata}, 16'h0);
    rreg(3'd1, v); chk("R1 icr", {8'h0, v}, 16'h0);
    rreg(3'd2, v); chk("R1 mode", {8'h0, v}, 16'h0);
    rreg(3'd5, v); chk("R1 bsr phase match at zero", {8'h0, v}, 16'h08);

    // R14 readback
    wreg(3'd2, 8'hBC); rreg(3'd2, v); chk("R14 mode", {8'h0, v}, 16'hBC);
    wreg(3'd2, 8'h00);
    wreg(3'd3, 8'hF5); rreg(3'd3, v); chk("R14 tcr", {8'h0, v}, 16'h05);
    wreg(3'd3, 8'h00);

    // R2 data in / out
    for (int i = 0; i < 6; i++) begin
      logic [7:0] od, dv;
      od = 8'($urandom); dv = 8'($urandom);
      o_data = od; idle(3);
      rreg(3'd0, v); chk("R2 live data", {8'h0, v}, {8'h0, od});
      wreg(3'd0, dv); wreg(3'd1, 8'h01); idle(2);
      chk("R5 data_oe", {15'b0, d_oe}, 16'h1);
      chk("R5 data_o", {8'h0, d_data}, {8'h0, dv});
      chk("R5 odd parity", {15'b0, ^{d_data, d_dbp}}, 16'h1);
      idle(3);
      rreg(3'd0, v); chk("R2 bus with own data", {8'h0, v}, {8'h0, od | dv});
      wreg(3'd1, 8'h00);
    end
    o_data = 0;
    wreg(3'd1, 8'h01); wreg(3'd3, 8'h01); idle(2);
    chk("R5 no drive on input phase", {15'b0, d_oe}, 16'h0);
    wreg(3'd1, 8'h00); wreg(3'd3, 8'h00);

    // R3 / R4 random line asserts
    for (int i = 0; i < 10; i++) begin
      logic [7:0] ic; logic tg; logic [3:0] tc;
      ic = 8'($urandom) & 8'h9F; tg = 1'($urandom); tc = 4'($urandom);
      wreg(3'd2, {1'b0, tg, 6'b0}); wreg(3'd3, {4'b0, tc}); wreg(3'd1, ic); idle(2);
      chk("R4 drives", {7'b0, d_rst, d_bsy, d_sel, d_atn, d_ack, d_req, d_msg, d_cd, d_io},
          {7'b0, exp_drv(ic, tg, tc)});
      rreg(3'd1, v); chk("R3 icr readback", {8'h0, v}, {8'h0, ic[7], 2'b00, ic[4:0]});
    end
    wreg(3'd2, 8'h00); wreg(3'd3, 8'h00);
    wreg(3'd1, 8'h4F); idle(2);
    chk("R3 tri-state", {12'b0, d_bsy, d_sel, d_atn, d_oe}, 16'h0);
    rreg(3'd1, v); chk("R3 tri bit reads aip", {8'h0, v}, 16'h0F);
    wreg(3'd1, 8'h20); idle(2);
    chk("R3 diff enable", {15'b0, d_diff}, 16'h1);
    rreg(3'd1, v); chk("R3 diff bit reads lost", {8'h0, v}, 16'h00);
    wreg(3'd1, 8'h00); idle(4);
    rreg(3'd7, v);

    // R6 / R7 random bus states
    for (int i = 0; i < 16; i++) begin
      logic [15:0] r; logic [2:0] tw;
      r = 16'($urandom); tw = 3'($urandom);
      {o_rst, o_bsy, o_sel, o_atn, o_ack, o_req, o_msg, o_cd, o_io, o_dbp} = r[9:0];
      o_data = r[15:8];
      wreg(3'd3, {5'b0, tw}); idle(3);
      rreg(3'd4, v); chk("R6 status", {8'h0, v}, {8'h0, exp_stat()});
      rreg(3'd5, v); chk("R7 bus and status", {8'h0, v}, {8'h0, exp_bsr(tw, 1'b0, 1'b0, 1'b0)});
    end
    {o_rst, o_bsy, o_sel, o_atn, o_ack, o_req, o_msg, o_cd, o_io, o_dbp} = '0;
    o_data = 0; wreg(3'd3, 8'h00); idle(4); rreg(3'd7, v);

    // R8 selection
    wreg(3'd4, 8'h08);
    o_data = 8'h08; o_sel = 1; idle(4);
    chk("R8 selection irq", {15'b0, irq}, 16'h1);
    rreg(3'd5, v); chk("R7 irq mirror", {8'h0, v}, 16'h18);
    rreg(3'd7, v); idle(1);
    chk("R9 irq cleared", {15'b0, irq}, 16'h0);
    o_sel = 0; o_data = 0; idle(4);
    o_data = 8'h10; o_sel = 1; idle(4);
    chk("R8 mask miss", {15'b0, irq}, 16'h0);
    o_sel = 0; idle(2); o_bsy = 1; o_data = 8'h08; idle(2); o_sel = 1; idle(4);
    chk("R8 busy blocks", {15'b0, irq}, 16'h0);
    o_sel = 0; o_bsy = 0; o_data = 0; wreg(3'd4, 8'h00); idle(4);

    // R10 parity
    wreg(3'd2, 8'h30);
    o_data = 8'h5A; o_dbp = 0; o_req = 1; idle(4); o_req = 0; idle(4);
    chk("R10 parity irq", {15'b0, irq}, 16'h1);
    rreg(3'd6, v); chk("R10 latched data", {8'h0, v}, 16'h5A);
    rreg(3'd5, v); chk("R10 parity flag", {8'h0, v}, 16'h38);
    rreg(3'd7, v); rreg(3'd5, v); chk("R9 flags cleared", {8'h0, v}, 16'h08);
    o_data = 8'h3C; o_dbp = 1; o_req = 1; idle(4); o_req = 0; idle(4);
    chk("R10 good parity", {15'b0, irq}, 16'h0);
    rreg(3'd6, v); chk("R10 latched good", {8'h0, v}, 16'h3C);
    wreg(3'd2, 8'h10);
    o_data = 8'h11; o_dbp = 0; o_req = 1; idle(4); o_req = 0; idle(4);
    rreg(3'd5, v); chk("R10 check disabled", {8'h0, v}, 16'h08);
    rreg(3'd6, v); chk("R10 latch without check", {8'h0, v}, 16'h11);
    wreg(3'd2, 8'h70);
    o_data = 8'h5A; o_req = 1; idle(4); o_req = 0; idle(4);
    chk("R10 target ignores REQ", {15'b0, irq}, 16'h0);
    o_ack = 1; idle(4); o_ack = 0; idle(4);
    chk("R10 target ACK edge", {15'b0, irq}, 16'h1);
    rreg(3'd7, v); wreg(3'd2, 8'h00); o_data = 0; o_dbp = 0; idle(4);

    // R11 busy monitor
    wreg(3'd2, 8'h04);
    o_bsy = 1; idle(4); o_bsy = 0; idle(4);
    chk("R11 busy loss irq", {15'b0, irq}, 16'h1);
    rreg(3'd5, v); chk("R11 busy flag", {8'h0, v}, 16'h1C);
    rreg(3'd7, v); rreg(3'd5, v); chk("R9 busy cleared", {8'h0, v}, 16'h08);
    wreg(3'd2, 8'h00);
    o_bsy = 1; idle(4); o_bsy = 0; idle(4);
    chk("R11 monitor off", {15'b0, irq}, 16'h0);

    // R12 phase mismatch
    wreg(3'd2, 8'h02); idle(2);
    o_io = 1; idle(4);
    chk("R12 mismatch irq", {15'b0, irq}, 16'h1);
    rreg(3'd5, v); chk("R12 match bit low", {8'h0, v}, 16'h10);
    rreg(3'd7, v); o_io = 0; idle(4);
    chk("R12 regain no irq", {15'b0, irq}, 16'h0);
    wreg(3'd2, 8'h00);
    o_cd = 1; idle(4);
    chk("R12 dma off", {15'b0, irq}, 16'h0);
    o_cd = 0; idle(4);

    // R13 arbitration win with lower id present
    o_data = 8'h01;
    wreg(3'd2, 8'h01);
    rreg(3'd1, v); chk("R13 waiting for free bus", {8'h0, v}, 16'h00);
    idle(FREE_N + ARB_N + 6);
    rreg(3'd1, v); chk("R13 won", {8'h0, v}, 16'h40);
    chk("R13 drive id", {6'b0, d_oe, d_bsy, d_data}, {6'b0, 2'b11, 8'h40});
    wreg(3'd2, 8'h00); idle(2);
    rreg(3'd1, v); chk("R13 ended", {8'h0, v}, 16'h00);
    chk("R13 released", {14'b0, d_oe, d_bsy}, 16'h0);
    o_data = 0;
    // busy bus holds off
    o_bsy = 1; wreg(3'd2, 8'h01); idle(FREE_N + ARB_N + 6);
    rreg(3'd1, v); chk("R13 held off by BSY", {8'h0, v}, 16'h00);
    o_bsy = 0; idle(FREE_N + ARB_N + 6);
    rreg(3'd1, v); chk("R13 won after free", {8'h0, v}, 16'h40);
    wreg(3'd2, 8'h00); idle(4);
    // higher id present
    o_data = 8'h80; wreg(3'd2, 8'h01); idle(FREE_N + ARB_N + 6);
    rreg(3'd1, v); chk("R13 lost", {8'h0, v}, 16'h20);
    chk("R13 lost releases", {14'b0, d_oe, d_bsy}, 16'h0);
    wreg(3'd2, 8'h00); idle(2);
    rreg(3'd1, v); chk("R13 lost cleared", {8'h0, v}, 16'h00);
    o_data = 0;

    done = 1;
    finish_run();
  end
endmodule